// File: doc/BRIEF.md
# Reflected CRC accumulate unit

This block performs one step of a running CRC computation, the way a processor's CRC instruction does. Each accepted request carries a 32-bit accumulator, a data operand, a size code and a polynomial select. One cycle later the block returns the updated accumulator. The data operand is taken from the low 8, 16 or 32 bits of the data input. The polynomial is either the common CRC-32 generator or the Castagnoli generator.

The accumulator, the data and the result all use the bit-reflected convention found in software CRC libraries. The block applies no initial or final inversion. The caller seeds the accumulator with 0xFFFFFFFF and inverts the final value when the standard check values are wanted.

The update is computed combinationally, as the equivalent right-shifting LFSR, one shift per data bit. One copy of this logic exists for each polynomial and size pair, and the result is captured in a register. A request is accepted on every cycle in which it is valid.

Top module: `crc_update_unit`

## Requirements
- R1: With poly_sel_i = 0, the generator is 0x04C11DB7 (normal form). Seeding with 0xFFFFFFFF, feeding the ASCII bytes "123456789" as byte updates and inverting the final value gives 0xCBF43926.
- R2: With poly_sel_i = 1, the generator is 0x1EDC6F41 (normal form). The same procedure gives 0xE3069283.
- R3: size_i encodes 00 = 8 bits, 01 = 16 bits, 10 = 32 bits. Only data_i[7:0], data_i[15:0] or data_i[31:0] respectively affect the result, and higher data bits are ignored.
- R4: The result equals the bit-reversal of the remainder of (rev32(acc) << n) XOR (rev_n(data) << 32) modulo the selected generator over GF(2), where n is the operand size. No inversion is applied, so a zero accumulator with zero data gives zero.
- R5: One 32-bit update of a word gives the same result as four 8-bit updates of its bytes, applied lowest byte first.
- R6: req_ready_o is always high. The result and res_valid_o appear on the clock edge that accepts the request, and res_valid_o is high for exactly one cycle per accepted request.
- R7: An accepted request with size_i = 11 raises err_o together with res_valid_o for that cycle and leaves res_o unchanged.
- R8: While rst_ni is low, res_o is 0 and res_valid_o and err_o are low.
- R9: res_o holds its value in cycles with no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready, always high |
| acc_i | input | 32 | Running accumulator, reflected |
| data_i | input | 32 | Data operand, low bits used according to size |
| size_i | input | 2 | Operand size code: 00 byte, 01 half, 10 word, 11 reserved |
| poly_sel_i | input | 1 | 0 selects CRC-32, 1 selects CRC32C |
| res_valid_o | output | 1 | Result valid, one cycle per request |
| res_o | output | 32 | Updated accumulator |
| err_o | output | 1 | Reserved size code was requested |

## Verification
The bench builds the unit with its default generator parameters, the CRC-32 and Castagnoli polynomials. These defaults make the published check strings a direct end-to-end test. With only 256 byte values, every byte can be swept against several accumulator seeds under both polynomials. Halfword and word operands are covered with random values checked against a long-division model, and word updates are compared with four chained byte updates. Junk in the unused upper data bits, the reserved size code and idle cycles are driven at the ports to confirm that the result register ignores them.

// File: rtl/crc_pkg.sv
package crc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } crc_size_e;

  localparam int CRC_W     = 32;
  localparam int NUM_SIZES = 3;
  localparam int NUM_POLYS = 2;

  function automatic logic [CRC_W-1:0] rev_bits(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/crc_lfsr_core.sv
// Reflected LFSR update: xor data into low bits, then W right shifts.
module crc_lfsr_core #(
  parameter int          W      = 8,
  parameter logic [31:0] POLY_R = 32'hEDB88320
) (
  input  logic [31:0]  acc_i,
  input  logic [W-1:0] data_i,
  output logic [31:0]  acc_o
);
  logic [31:0] seed;

  if (W < 32) begin : g_narrow
    assign seed = acc_i ^ {{(32-W){1'b0}}, data_i};
  end else begin : g_full
    assign seed = acc_i ^ data_i[31:0];
  end

  always_comb begin
    logic [31:0] c;
    c = seed;
    for (int i = 0; i < W; i++) begin
      c = c[0] ? ((c >> 1) ^ POLY_R) : (c >> 1);
    end
    acc_o = c;
  end
endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_pkg::*;
#(
  parameter logic [31:0] POLY_STD  = 32'h04C11DB7,
  parameter logic [31:0] POLY_CAST = 32'h1EDC6F41
) (
  input  logic [31:0] acc_i,
  input  logic [31:0] data_i,
  input  logic [1:0]  size_i,
  input  logic        poly_sel_i,
  output logic [31:0] nxt_o,
  output logic        illegal_o
);
  localparam logic [31:0] POLY_R [NUM_POLYS] = '{rev_bits(POLY_STD), rev_bits(POLY_CAST)};

  logic [31:0] cand [NUM_POLYS][NUM_SIZES];

  for (genvar p = 0; p < NUM_POLYS; p++) begin : g_poly
    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      localparam int W = 8 << s;
      crc_lfsr_core #(
        .W     (W),
        .POLY_R(POLY_R[p])
      ) u_core (
        .acc_i (acc_i),
        .data_i(data_i[W-1:0]),
        .acc_o (cand[p][s])
      );
    end
  end

  always_comb begin
    nxt_o     = acc_i;
    illegal_o = 1'b0;
    unique case (crc_size_e'(size_i))
      SZ_BYTE: nxt_o = cand[poly_sel_i][0];
      SZ_HALF: nxt_o = cand[poly_sel_i][1];
      SZ_WORD: nxt_o = cand[poly_sel_i][2];
      default: illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/crc_update_unit.sv
module crc_update_unit #(
  parameter logic [31:0] POLY_STD  = 32'h04C11DB7,
  parameter logic [31:0] POLY_CAST = 32'h1EDC6F41
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] acc_i,
  input  logic [31:0] data_i,
  input  logic [1:0]  size_i,
  input  logic        poly_sel_i,
  output logic        res_valid_o,
  output logic [31:0] res_o,
  output logic        err_o
);
  logic [31:0] nxt;
  logic        illegal;
  logic        accept;

  assign req_ready_o = 1'b1;
  assign accept      = req_valid_i & req_ready_o;

  crc_datapath #(
    .POLY_STD (POLY_STD),
    .POLY_CAST(POLY_CAST)
  ) u_dp (
    .acc_i     (acc_i),
    .data_i    (data_i),
    .size_i    (size_i),
    .poly_sel_i(poly_sel_i),
    .nxt_o     (nxt),
    .illegal_o (illegal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o       <= '0;
      res_valid_o <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      res_valid_o <= accept;
      err_o       <= accept & illegal;
      if (accept && !illegal) res_o <= nxt;
    end
  end

  p_valid_follows_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);
  p_no_spurious_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o);
  p_rsvd_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && size_i == 2'b11) |=> (err_o && $stable(res_o)));
  p_err_with_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> res_valid_o);
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(res_o));
  p_zero_in_zero_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && acc_i == 32'h0 && data_i == 32'h0 && size_i != 2'b11) |=> res_o == 32'h0);
endmodule

// File: tb/crc_update_unit_test.sv
module crc_update_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] acc = '0;
  logic [31:0] data = '0;
  logic [1:0]  size = '0;
  logic        psel = 1'b0;
  logic        res_valid;
  logic [31:0] res;
  logic        err;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  crc_update_unit uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid),
    .req_ready_o(req_ready),
    .acc_i      (acc),
    .data_i     (data),
    .size_i     (size),
    .poly_sel_i (psel),
    .res_valid_o(res_valid),
    .res_o      (res),
    .err_o      (err)
  );

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // Long division per R4, independent of the LFSR form.
  function automatic logic [31:0] ref_crc(input logic [31:0] a, input logic [31:0] d,
                                          input int n, input bit p);
    logic [63:0] m;
    logic [63:0] rd;
    logic [32:0] g;
    g  = {1'b1, (p ? 32'h1EDC6F41 : 32'h04C11DB7)};
    rd = '0;
    for (int k = 0; k < n; k++) rd[n-1-k] = d[k];
    m = ({32'h0, rev32(a)} << n) ^ (rd << 32);
    for (int i = 63; i >= 32; i--) begin
      if (m[i]) m = m ^ ({31'h0, g} << (i - 32));
    end
    return rev32(m[31:0]);
  endfunction

  function automatic int sz_bits(input logic [1:0] s);
    return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] a, input logic [31:0] d, input logic [1:0] s,
                      input bit p, output logic [31:0] r, output bit v, output bit e);
    @(negedge clk);
    acc = a; data = d; size = s; psel = p; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    data = $urandom;
    r = res; v = res_valid; e = err;
  endtask

  task automatic run_check_string(input bit p, input logic [31:0] exp, input string req);
    logic [31:0] c, r;
    bit v, e;
    string msg;
    c   = 32'hFFFFFFFF;
    msg = "123456789";
    for (int i = 0; i < msg.len(); i++) begin
      step(c, {24'h0, msg[i]}, 2'b00, p, r, v, e);
      c = r;
    end
    chk(~c == exp, req, ~c, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r, r2, exp, prev, c, w;
    bit v, e;
    logic [31:0] seeds [3] = '{32'h0, 32'hFFFFFFFF, 32'h12345678};

    repeat (3) @(negedge clk);
    // R8
    chk(res == 32'h0 && !res_valid && !err, "R8 reset", {res[31:2], res_valid, err}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    chk(req_ready == 1'b1, "R6 ready", {31'h0, req_ready}, 32'h1);

    // R1, R2
    run_check_string(1'b0, 32'hCBF43926, "R1 crc32 check");
    run_check_string(1'b1, 32'hE3069283, "R2 crc32c check");

    // R4: zero stays zero
    step(32'h0, 32'h0, 2'b10, 1'b0, r, v, e);
    chk(r == 32'h0, "R4 zero", r, 32'h0);

    // R3, R4: every byte, junk in upper bits, several seeds, both polys
    for (int p = 0; p < 2; p++)
      for (int si = 0; si < 3; si++)
        for (int b = 0; b < 256; b++) begin
          logic [31:0] junk;
          junk = {$urandom} & 32'hFFFFFF00;
          exp  = ref_crc(seeds[si], {24'h0, b[7:0]}, 8, p[0]);
          step(seeds[si], junk | b[7:0], 2'b00, p[0], r, v, e);
          chk(r == exp && v && !e, "R3 R4 byte sweep", r, exp);
        end

    // R3, R4: halfwords and words
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 200; k++) begin
        logic [1:0]  s;
        logic [31:0] a, d;
        s = (k % 2 == 0) ? 2'b01 : 2'b10;
        a = $urandom;
        d = $urandom;
        exp = ref_crc(a, (s == 2'b01) ? {16'h0, d[15:0]} : d, sz_bits(s), p[0]);
        step(a, d, s, p[0], r, v, e);
        chk(r == exp, "R3 R4 half/word", r, exp);
      end

    // R5: word vs four bytes, lowest first
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 100; k++) begin
        logic [31:0] a;
        a = $urandom;
        w = $urandom;
        step(a, w, 2'b10, p[0], r2, v, e);
        c = a;
        for (int j = 0; j < 4; j++) begin
          step(c, {24'hABCDEF, w[8*j +: 8]}, 2'b00, p[0], r, v, e);
          c = r;
        end
        chk(c == r2, "R5 word vs bytes", c, r2);
        exp = ref_crc(a, w, 32, p[0]);
        chk(r2 == exp, "R5 word ref", r2, exp);
      end

    // R6: valid pulse lasts one cycle
    step(32'hDEADBEEF, 32'h55, 2'b00, 1'b0, r, v, e);
    chk(v == 1'b1, "R6 valid high", {31'h0, v}, 32'h1);
    prev = r;
    @(negedge clk);
    chk(res_valid == 1'b0, "R6 valid drops", {31'h0, res_valid}, 32'h0);
    // R9: idle hold
    repeat (5) @(negedge clk);
    chk(res == prev, "R9 idle hold", res, prev);

    // R7: reserved size
    for (int p = 0; p < 2; p++) begin
      step(32'hCAFEF00D, 32'h01020304, 2'b11, p[0], r, v, e);
      chk(e && v, "R7 err flag", {30'h0, v, e}, 32'h3);
      chk(r == prev, "R7 result held", r, prev);
      @(negedge clk);
      chk(err == 1'b0, "R7 err clears", {31'h0, err}, 32'h0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule